// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-level controller of an expansion card that is configured through three fixed-function I/O ports on a legacy 8-bit bus. Software writes a register index to an index port and then writes a value to a write port. Register reads come back through a read port whose I/O location software can move. The controller tracks which of four card states the card is in: waiting for the unlock key, sleeping, isolating, or being configured. It holds the card's select number and the currently selected logical device, and it decodes the card-level command registers.

The initiation-key sequence is outside this block and arrives as a single-cycle pulse. Resource data is a small internal table that is read one byte at a time. The table is computed, not stored: byte k equals (29*k + 53) mod 256. A status bit tells software when another byte may be read. Control actions written to the command register act once and clear themselves, so the register never holds them.

Top module: `card_cfg_ctrl`

## Requirements
- R1: After reset the card state is wait-for-key (code 0), the select number is 0, the read port address is 0, the device select is 0 and the device-reset pulse is low.
- R2: A key pulse moves the card from wait-for-key (0) to sleep (1). A key pulse in any other state has no effect.
- R3: In wait-for-key, data writes to any register are ignored: the select number and the state do not change.
- R4: A data write to register 3 (wake) with a byte equal to the select number moves a sleeping card to isolation (2) if the byte is zero, or to config (3) if the byte is nonzero. A non-matching byte leaves the state unchanged.
- R5: A matching wake write also rewinds the resource pointer, so the next read of register 4 returns table byte 0.
- R6: A data write to register 6 loads the select number when the card is in isolation or config, and a write in isolation also moves the card to config. In config a read of register 6 returns the select number.
- R7: In config, a data write of byte D to register 0 sets the read port address output to {D, 2'b00}. In any other state the write is ignored.
- R8: In config, a write to register 2 acts on its bits. Bit 2 clears the select number. Bit 1 returns the card to wait-for-key and keeps the select number. Bit 0 raises the device-reset output for exactly the one cycle after the write, forces the device select to 0 and keeps the select number. A read of register 2 returns 0.
- R9: Bit 0 of register 5 is 1 while unread table bytes remain (9 bytes by default). Each read of register 4 in config returns the current byte (29*k + 53) mod 256 and advances the pointer. Once the table is used up, register 4 reads 0, the pointer does not advance, and the status bit is 0.
- R10: With one logical device, register 7 reads 0x00 and writes to it do not change it.
- R11: Reads of any register return 0x00 outside config.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyPulse | input | 1 | Single-cycle pulse: unlock key detected |
| addrWe | input | 1 | Write strobe of the index port |
| dataWe | input | 1 | Write strobe of the write-data port |
| rdEn | input | 1 | Read strobe of the read-data port |
| busData | input | 8 | Bus write data |
| rdData | output | 8 | Read-data port value for the selected register |
| rdPortAddr | output | 10 | Current I/O address of the read-data port |
| cardState | output | 2 | Card state: 0 wait-for-key, 1 sleep, 2 isolation, 3 config |
| selNum | output | 8 | Card select number |
| devSel | output | 8 | Selected logical device |
| devReset | output | 1 | One-cycle logical-device reset pulse |

## Verification
A wrong state code shows up at once on cardState. It also changes which later writes take effect, so a card stuck outside config leaves the select number and the read port address frozen, and every read comes back 0. A pointer that fails to rewind or that runs past the end of the table is seen on the very next register 4 or register 5 read. A control bit that fails to clear itself shows as a device-reset pulse longer than one cycle, or as a nonzero read of register 2.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } cardState_e;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic setRdPort;
    logic clrSel;
    logic loadSel;
    logic loadDev;
    logic rstDev;
    logic rstPtr;
    logic advPtr;
  } strobes_t;

  localparam logic [7:0] REG_RDPORT = 8'h00;
  localparam logic [7:0] REG_CTRL   = 8'h02;
  localparam logic [7:0] REG_WAKE   = 8'h03;
  localparam logic [7:0] REG_RES    = 8'h04;
  localparam logic [7:0] REG_STAT   = 8'h05;
  localparam logic [7:0] REG_SEL    = 8'h06;
  localparam logic [7:0] REG_DEV    = 8'h07;

endpackage

// File: rtl/card_cfg_ctl.sv
module card_cfg_ctl
  import card_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyPulse,
  input  logic       dataWe,
  input  logic       rdEn,
  input  logic [7:0] busData,
  input  logic [7:0] regAddr,
  input  logic [7:0] selNum,
  input  logic       resReady,
  output cardState_e state,
  output strobes_t   stb
);

  cardState_e nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    if (dataWe && state != ST_WAIT_KEY) begin
      unique case (regAddr)
        REG_WAKE: begin
          if (busData == selNum) begin
            stb.rstPtr = 1'b1;
            if (state == ST_SLEEP)
              nextState = (busData == 8'd0) ? ST_ISOLATE : ST_CONFIG;
          end
        end
        REG_SEL: begin
          if (state == ST_CONFIG || state == ST_ISOLATE) begin
            stb.loadSel = 1'b1;
            if (state == ST_ISOLATE) nextState = ST_CONFIG;
          end
        end
        REG_RDPORT: stb.setRdPort = (state == ST_CONFIG);
        REG_CTRL: begin
          if (state == ST_CONFIG) begin
            stb.clrSel = busData[2];
            stb.rstDev = busData[0];
            if (busData[1]) nextState = ST_WAIT_KEY;
          end
        end
        REG_DEV: stb.loadDev = (state == ST_CONFIG);
        default: ;
      endcase
    end
    if (keyPulse && state == ST_WAIT_KEY) nextState = ST_SLEEP;
    stb.advPtr = rdEn && state == ST_CONFIG && regAddr == REG_RES && resReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_WAIT_KEY;
    else       state <= nextState;
  end

endmodule

// File: rtl/card_cfg_dp.sv
module card_cfg_dp
  import card_cfg_pkg::*;
#(
  parameter int ROM_DEPTH = 9,
  parameter int NUM_DEV   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrWe,
  input  logic [7:0] busData,
  input  strobes_t   stb,
  input  logic       isConfig,
  output logic [7:0] regAddr,
  output logic [7:0] selNum,
  output logic [7:0] devSel,
  output logic [9:0] rdPortAddr,
  output logic       devReset,
  output logic       resReady,
  output logic [7:0] rdData
);

  localparam int PTR_W = $clog2(ROM_DEPTH + 1);
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [PTR_W-1:0] DEPTH_L = PTR_W'(ROM_DEPTH);

  logic [7:0]       rdPortReg;
  logic [PTR_W-1:0] ptr;

  function automatic logic [7:0] romByte(input logic [PTR_W-1:0] idx);
    romByte = 8'(idx) * 8'd29 + 8'd53;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAddr   <= '0;
      selNum    <= '0;
      rdPortReg <= '0;
      ptr       <= '0;
      devReset  <= 1'b0;
    end else begin
      if (addrWe)         regAddr   <= busData;
      if (stb.clrSel)     selNum    <= '0;
      else if (stb.loadSel) selNum  <= busData;
      if (stb.setRdPort)  rdPortReg <= busData;
      if (stb.rstPtr)     ptr       <= '0;
      else if (stb.advPtr) ptr      <= ptr + 1'b1;
      devReset <= stb.rstDev;
    end
  end

  generate
    if (NUM_DEV > 1) begin : g_multiDev
      logic [DEV_W-1:0] devReg;
      always_ff @(posedge clk) begin
        if (!rstN || stb.rstDev) devReg <= '0;
        else if (stb.loadDev && 32'(busData) < NUM_DEV) devReg <= busData[DEV_W-1:0];
      end
      assign devSel = 8'(devReg);
    end else begin : g_singleDev
      assign devSel = 8'h00;
    end
  endgenerate

  assign resReady   = ptr < DEPTH_L;
  assign rdPortAddr = {rdPortReg, 2'b00};

  always_comb begin
    rdData = 8'h00;
    if (isConfig) begin
      unique case (regAddr)
        REG_RES:  rdData = resReady ? romByte(ptr) : 8'h00;
        REG_STAT: rdData = {7'b0, resReady};
        REG_SEL:  rdData = selNum;
        REG_DEV:  rdData = devSel;
        default:  rdData = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/card_cfg_ctrl.sv
module card_cfg_ctrl
  import card_cfg_pkg::*;
#(
  parameter int ROM_DEPTH = 9,
  parameter int NUM_DEV   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyPulse,
  input  logic       addrWe,
  input  logic       dataWe,
  input  logic       rdEn,
  input  logic [7:0] busData,
  output logic [7:0] rdData,
  output logic [9:0] rdPortAddr,
  output logic [1:0] cardState,
  output logic [7:0] selNum,
  output logic [7:0] devSel,
  output logic       devReset
);

  cardState_e state;
  strobes_t   stb;
  logic [7:0] regAddr;
  logic       resReady;

  card_cfg_ctl u_ctl (
    .clk(clk), .rstN(rstN), .keyPulse(keyPulse), .dataWe(dataWe), .rdEn(rdEn),
    .busData(busData), .regAddr(regAddr), .selNum(selNum), .resReady(resReady),
    .state(state), .stb(stb)
  );

  card_cfg_dp #(.ROM_DEPTH(ROM_DEPTH), .NUM_DEV(NUM_DEV)) u_dp (
    .clk(clk), .rstN(rstN), .addrWe(addrWe), .busData(busData), .stb(stb),
    .isConfig(state == ST_CONFIG), .regAddr(regAddr), .selNum(selNum),
    .devSel(devSel), .rdPortAddr(rdPortAddr), .devReset(devReset),
    .resReady(resReady), .rdData(rdData)
  );

  assign cardState = state;

endmodule

// File: rtl/card_cfg_chk.sv
module card_cfg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       keyPulse,
  input logic       dataWe,
  input logic [7:0] busData,
  input logic [7:0] regAddr,
  input logic [1:0] cardState,
  input logic [7:0] selNum,
  input logic [7:0] devSel,
  input logic       devReset
);

  assert_wait_exit_R2: assert property (@(posedge clk) disable iff (!rstN)
    cardState == 2'd0 |=> (cardState == 2'd0 || cardState == 2'd1));

  assert_key_wake_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cardState == 2'd0 && keyPulse) |=> cardState == 2'd1);

  assert_locked_sel_R3: assert property (@(posedge clk) disable iff (!rstN)
    cardState == 2'd0 |=> $stable(selNum));

  assert_wake_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cardState == 2'd1 && dataWe && regAddr == 8'h03 && busData == selNum && busData == 8'd0)
      |=> cardState == 2'd2);

  assert_wake_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cardState == 2'd1 && dataWe && regAddr == 8'h03 && busData == selNum && busData != 8'd0)
      |=> cardState == 2'd3);

  assert_isolate_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cardState == 2'd2 && dataWe && regAddr == 8'h06)
      |=> (cardState == 2'd3 && selNum == $past(busData)));

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    devReset |-> $past(dataWe && regAddr == 8'h02 && busData[0] && cardState == 2'd3));

  assert_pulse_devsel_R8: assert property (@(posedge clk) disable iff (!rstN)
    devReset |-> devSel == 8'h00);

endmodule

bind card_cfg_ctrl card_cfg_chk u_chk (
  .clk(clk), .rstN(rstN), .keyPulse(keyPulse), .dataWe(dataWe), .busData(busData),
  .regAddr(regAddr), .cardState(cardState), .selNum(selNum), .devSel(devSel),
  .devReset(devReset)
);

// File: tb/card_cfg_ctrl_test.sv
module card_cfg_ctrl_test;

  localparam int DEPTH = 9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       keyPulse = 1'b0, addrWe = 1'b0, dataWe = 1'b0, rdEn = 1'b0;
  logic [7:0] busData = 8'h00;
  logic [7:0] rdData, selNum, devSel;
  logic [9:0] rdPortAddr;
  logic [1:0] cardState;
  logic       devReset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  card_cfg_ctrl #(.ROM_DEPTH(DEPTH), .NUM_DEV(1)) uut (
    .clk(clk), .rstN(rstN), .keyPulse(keyPulse), .addrWe(addrWe), .dataWe(dataWe),
    .rdEn(rdEn), .busData(busData), .rdData(rdData), .rdPortAddr(rdPortAddr),
    .cardState(cardState), .selNum(selNum), .devSel(devSel), .devReset(devReset)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrAddr(input logic [7:0] a);
    @(negedge clk); addrWe = 1'b1; busData = a;
    @(negedge clk); addrWe = 1'b0;
  endtask

  task automatic wrData(input logic [7:0] d);
    @(negedge clk); dataWe = 1'b1; busData = d;
    @(negedge clk); dataWe = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wrAddr(a); wrData(d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    wrAddr(a);
    rdEn = 1'b1; #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic key();
    @(negedge clk); keyPulse = 1'b1;
    @(negedge clk); keyPulse = 1'b0;
  endtask

  function automatic logic [7:0] expByte(input int k);
    return 8'((k * 29 + 53) % 256);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cardState == 2'd0, "R1 state", cardState, 0);
    check(selNum == 8'd0, "R1 selNum", selNum, 0);
    check(rdPortAddr == 10'd0, "R1 rdPortAddr", rdPortAddr, 0);
    check(devSel == 8'd0 && devReset == 1'b0, "R1 devSel/devReset", {devSel, devReset}, 0);

    // R3 writes ignored while locked
    wr(8'h06, 8'h33);
    check(selNum == 8'd0, "R3 selNum", selNum, 0);
    wr(8'h03, 8'h00);
    check(cardState == 2'd0, "R3 state", cardState, 0);
    // R11 reads return 0 outside config
    rd(8'h05, v);
    check(v == 8'h00, "R11 read in wait-for-key", v, 0);

    // R2 key
    key();
    check(cardState == 2'd1, "R2 to sleep", cardState, 1);
    key();
    check(cardState == 2'd1, "R2 key in sleep", cardState, 1);

    // R4 wake
    wr(8'h03, 8'h05);
    check(cardState == 2'd1, "R4 mismatch", cardState, 1);
    wrData(8'h00);
    check(cardState == 2'd2, "R4 wake zero", cardState, 2);

    // R7 ignored in isolation, R6 load in isolation
    wr(8'h00, 8'h12);
    check(rdPortAddr == 10'd0, "R7 ignored in isolation", rdPortAddr, 0);
    wr(8'h06, 8'h07);
    check(cardState == 2'd3, "R6 to config", cardState, 3);
    check(selNum == 8'h07, "R6 selNum", selNum, 7);
    rd(8'h06, v);
    check(v == 8'h07, "R6 readback", v, 7);

    // R7 in config
    wr(8'h00, 8'h5A);
    check(rdPortAddr == 10'h168, "R7 rdPortAddr", rdPortAddr, 10'h168);
    rd(8'h02, v);
    check(v == 8'h00, "R8 ctrl reads 0", v, 0);
    wr(8'h07, 8'h03);
    rd(8'h07, v);
    check(v == 8'h00 && devSel == 8'h00, "R10 dev fixed", v, 0);

    // R9 resource table
    for (int k = 0; k < DEPTH; k++) begin
      rd(8'h05, v);
      check(v == 8'h01, "R9 ready", v, 1);
      rd(8'h04, v);
      check(v == expByte(k), "R9 byte", v, expByte(k));
    end
    rd(8'h05, v);
    check(v == 8'h00, "R9 ready at end", v, 0);
    rd(8'h04, v);
    check(v == 8'h00, "R9 byte at end", v, 0);
    rd(8'h04, v);
    check(v == 8'h00, "R9 no advance at end", v, 0);

    // R5 wake rewinds pointer, config state kept
    wr(8'h03, 8'h07);
    check(cardState == 2'd3, "R5 state kept", cardState, 3);
    rd(8'h04, v);
    check(v == expByte(0), "R5 rewind", v, expByte(0));
    rd(8'h04, v);
    check(v == expByte(1), "R5 advance", v, expByte(1));

    // R8 bit 0 pulse
    wrAddr(8'h02);
    @(negedge clk); dataWe = 1'b1; busData = 8'h01;
    @(negedge clk); dataWe = 1'b0;
    check(devReset == 1'b1, "R8 pulse high", devReset, 1);
    @(negedge clk);
    check(devReset == 1'b0, "R8 pulse one cycle", devReset, 0);
    check(selNum == 8'h07 && cardState == 2'd3, "R8 bit0 keeps sel", selNum, 7);

    // R8 bit 1
    wr(8'h02, 8'h02);
    check(cardState == 2'd0, "R8 bit1 state", cardState, 0);
    check(selNum == 8'h07, "R8 bit1 keeps sel", selNum, 7);
    rd(8'h06, v);
    check(v == 8'h00, "R11 sel read locked", v, 0);

    // R4 sweep of non-matching wake bytes
    key();
    wrAddr(8'h03);
    for (int d = 0; d < 256; d++) begin
      if (d != 7) begin
        wrData(8'(d));
        check(cardState == 2'd1, "R4 sweep mismatch", cardState, 1);
      end
    end
    rd(8'h06, v);
    check(v == 8'h00, "R11 sel read sleep", v, 0);
    key();
    check(cardState == 2'd1, "R2 key ignored", cardState, 1);
    wr(8'h06, 8'h44);
    check(selNum == 8'h07, "R6 ignored in sleep", selNum, 7);
    wr(8'h03, 8'h07);
    check(cardState == 2'd3, "R4 wake nonzero", cardState, 3);

    // R8 bit 2
    wr(8'h02, 8'h04);
    check(selNum == 8'h00 && cardState == 2'd3, "R8 bit2 clears sel", selNum, 0);
    wr(8'h02, 8'h02);
    check(cardState == 2'd0, "R8 back to wait", cardState, 0);

    // R7 sweep of read port locations
    key();
    wr(8'h03, 8'h00);
    wr(8'h06, 8'h01);
    check(cardState == 2'd3, "R6 to config again", cardState, 3);
    wrAddr(8'h00);
    for (int d = 0; d < 256; d += 17) begin
      wrData(8'(d));
      check(rdPortAddr == 10'(d * 4), "R7 sweep", rdPortAddr, d * 4);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule